// File: doc/BRIEF.md
# Single-Channel DMA Mover with Byte-Order Reversal

This block is one unidirectional DMA channel. It copies a programmed number of elements from a source region to a destination region over a 32-bit bus master port. Either side may be a memory, where the address walks forward, or a peripheral, where the address stays put and a request/acknowledge pair paces the traffic. This covers memory-to-memory, memory-to-peripheral, peripheral-to-memory and peripheral-to-peripheral copies. A device that both sends and receives needs two of these channels.

Software programs the channel through a small word-wide register port. It sets the source and destination addresses, the element count, the element width, a byte-order reversal switch and the side types, and then sets the enable bit. The channel reads one element, optionally reverses its bytes, writes it, and repeats until the count reaches zero. It then drops its enable bit and flags completion. An error response on any bus access halts the channel and latches one sticky abort flag. An interrupt line can report that flag when a mask bit allows it.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset every register reads zero, `m_req`, both acknowledge outputs and both interrupt outputs are low.
- R2: `reg_word` selects a 32-bit register: 0 source address, 1 destination address, 2 element count (low 16 bits), 3 control, 4 status. Control bits are: bit 0 enable, bits 2:1 width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), bit 3 swap, bit 4 source is peripheral, bit 5 destination is peripheral, bit 6 abort interrupt mask. Status bit 0 is abort and bit 1 is done. Written control and address values read back unchanged.
- R3: The channel reads one element (`m_write` low), then writes it (`m_write` high), before it issues the next read. While `m_req` is high and `m_ready` is low, the address, direction and write data hold steady.
- R4: After each completed element, a memory-side address advances by 1, 2 or 4 for width codes 0, 1 and 2. A peripheral-side address never changes.
- R5: `m_size` carries the width code. The read element is taken from the byte lanes starting at lane `addr[1:0]` of the source address. The write element is placed on the lanes starting at lane `addr[1:0]` of the destination address, in little-endian lane order.
- R6: With swap set, the bytes of each element are reversed: the two bytes of a 16-bit element trade places, and the four bytes of a 32-bit element reverse order. 8-bit elements pass unchanged.
- R7: A peripheral source is read only after `src_dreq` is seen high. A peripheral destination is written only while `dst_dreq` is high. `src_dack` and `dst_dack` pulse for the one cycle in which the matching peripheral access completes, never for a memory side, and never both at once.
- R8: The count drops by one per completed element. When it reaches zero the channel clears its enable bit and sets done, and `irq_done` follows the done bit. Enabling with a count of zero sets done with no bus traffic.
- R9: An access that completes with `m_err` high stops the channel. The enable bit clears, the abort bit sets, no further request is issued, and the failed element is not counted.
- R10: Abort and done are sticky and clear only when 1 is written to their status bit. `irq_abort` is high exactly when abort is set and the control mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register word write strobe |
| reg_word | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| m_req | output | 1 | Bus access request |
| m_write | output | 1 | Access direction, 1 = write |
| m_addr | output | 32 | Byte address of the access |
| m_size | output | 2 | Width code of the access |
| m_wdata | output | 32 | Write data on the byte lanes |
| m_rdata | input | 32 | Read data on the byte lanes |
| m_ready | input | 1 | Access completes this cycle |
| m_err | input | 1 | Completing access reports an error |
| src_dreq | input | 1 | Source peripheral has data |
| src_dack | output | 1 | Source peripheral element taken |
| dst_dreq | input | 1 | Destination peripheral has room |
| dst_dack | output | 1 | Destination peripheral element delivered |
| irq_done | output | 1 | Transfer complete interrupt |
| irq_abort | output | 1 | Masked abort interrupt |

## Verification
The bench aims at lane handling at unaligned sub-word addresses. A design that shifts by the wrong lane or swaps 8-bit elements writes scrambled bytes that the scoreboard sees at once. Peripheral sides are held off with their request lines low: a channel that ignores pacing issues early accesses, and one that advances a fixed peripheral address reads back a moved register value. Errors are injected on a mid-transfer read and on a mid-transfer write, with the interrupt mask both set and clear. A channel that keeps running, counts the failed element or ignores the mask shows the wrong count, stray writes or a wrong interrupt level. A zero count must finish with no bus traffic.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;
    localparam int WSEL_W = 3;

    // register word indices
    localparam logic [WSEL_W-1:0] W_SRC  = 3'd0;
    localparam logic [WSEL_W-1:0] W_DST  = 3'd1;
    localparam logic [WSEL_W-1:0] W_CNT  = 3'd2;
    localparam logic [WSEL_W-1:0] W_CTRL = 3'd3;
    localparam logic [WSEL_W-1:0] W_STAT = 3'd4;

    localparam int CTRL_W = 7;

    // width codes
    localparam logic [1:0] WID_8  = 2'd0;
    localparam logic [1:0] WID_16 = 2'd1;

    // control word, MSB first so it maps onto bits 6..0
    typedef struct packed {
        logic       abort_mask;
        logic       dst_per;
        logic       src_per;
        logic       swap;
        logic [1:0] wid;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_st_e;

    function automatic logic [2:0] elem_bytes(input logic [1:0] wid);
        case (wid)
            WID_8:   return 3'd1;
            WID_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] wid);
        case (wid)
            WID_8:   return BUS_W'(8'hFF);
            WID_16:  return BUS_W'(16'hFFFF);
            default: return '1;
        endcase
    endfunction

    // reverse the byte order inside one element of the given width
    function automatic logic [BUS_W-1:0] byte_rev(input logic [BUS_W-1:0] v,
                                                  input logic [1:0] wid);
        logic [BUS_W-1:0] r;
        r = '0;
        case (wid)
            WID_8:  r = v;
            WID_16: r[15:0] = {v[7:0], v[15:8]};
            default: begin
                for (int b = 0; b < LANES; b++) begin
                    r[8*b +: 8] = v[8*(LANES-1-b) +: 8];
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [WSEL_W-1:0] reg_word,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              step,
    input  logic              finish,
    input  logic              abort_evt,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic              abort_flag,
    output logic              done_flag
);

    logic [ADDR_W-1:0] stride;
    assign stride = ADDR_W'(elem_bytes(ctrl.wid));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr   <= '0;
            dst_addr   <= '0;
            count      <= '0;
            ctrl       <= '0;
            abort_flag <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            if (reg_wen) begin
                case (reg_word)
                    W_SRC:  src_addr <= reg_wdata[ADDR_W-1:0];
                    W_DST:  dst_addr <= reg_wdata[ADDR_W-1:0];
                    W_CNT:  count    <= reg_wdata[CNT_W-1:0];
                    W_CTRL: ctrl     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    W_STAT: begin
                        abort_flag <= abort_flag & ~reg_wdata[0];
                        done_flag  <= done_flag  & ~reg_wdata[1];
                    end
                    default: ;
                endcase
            end
            // channel events take precedence over a same-cycle software write
            if (step) begin
                if (!ctrl.src_per) src_addr <= src_addr + stride;
                if (!ctrl.dst_per) dst_addr <= dst_addr + stride;
                count <= count - CNT_W'(1);
            end
            if (finish) begin
                ctrl.en   <= 1'b0;
                done_flag <= 1'b1;
            end
            if (abort_evt) begin
                ctrl.en    <= 1'b0;
                abort_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_word)
            W_SRC:   reg_rdata = BUS_W'(src_addr);
            W_DST:   reg_rdata = BUS_W'(dst_addr);
            W_CNT:   reg_rdata = BUS_W'(count);
            W_CTRL:  reg_rdata = BUS_W'(ctrl);
            W_STAT:  reg_rdata = BUS_W'({done_flag, abort_flag});
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_xfer_lane.sv
module dma_xfer_lane
    import dma_xfer_pkg::*;
(
    input  logic [BUS_W-1:0] rd_word,
    input  logic [1:0]       src_lo,
    input  logic [1:0]       dst_lo,
    input  logic [1:0]       wid,
    input  logic             swap,
    input  logic [BUS_W-1:0] elem_q,
    output logic [BUS_W-1:0] elem_in,
    output logic [BUS_W-1:0] wr_word
);

    logic [BUS_W-1:0] msk;
    logic [BUS_W-1:0] picked;

    always_comb begin
        msk     = lane_mask(wid);
        picked  = (rd_word >> {src_lo, 3'b000}) & msk;
        elem_in = swap ? byte_rev(picked, wid) : picked;
        wr_word = (elem_q & msk) << {dst_lo, 3'b000};
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              src_per,
    input  logic              dst_per,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              src_dreq,
    input  logic              dst_dreq,
    input  logic              m_ready,
    input  logic              m_err,
    input  logic [BUS_W-1:0]  elem_in,
    output logic              m_req,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [BUS_W-1:0]  elem_q,
    output logic              step,
    output logic              finish,
    output logic              abort_evt,
    output logic              src_dack,
    output logic              dst_dack
);

    seq_st_e st, nxt;
    logic    wr_go;

    always_comb begin
        nxt       = st;
        m_req     = 1'b0;
        m_write   = 1'b0;
        m_addr    = src_addr;
        step      = 1'b0;
        finish    = 1'b0;
        abort_evt = 1'b0;
        src_dack  = 1'b0;
        dst_dack  = 1'b0;
        wr_go     = !dst_per || dst_dreq;
        case (st)
            ST_IDLE: begin
                if (en) begin
                    if (count == '0) begin
                        finish = 1'b1;
                    end else if (!src_per || src_dreq) begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_READ: begin
                m_req = 1'b1;
                if (m_ready) begin
                    if (m_err) begin
                        abort_evt = 1'b1;
                        nxt       = ST_IDLE;
                    end else begin
                        src_dack = src_per;
                        nxt      = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                m_write = 1'b1;
                m_addr  = dst_addr;
                m_req   = wr_go;
                if (wr_go && m_ready) begin
                    nxt = ST_IDLE;
                    if (m_err) begin
                        abort_evt = 1'b1;
                    end else begin
                        step     = 1'b1;
                        dst_dack = dst_per;
                        finish   = (count == CNT_W'(1));
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            elem_q <= '0;
        end else begin
            st <= nxt;
            if (st == ST_READ && m_ready && !m_err) begin
                elem_q <= elem_in;
            end
        end
    end

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [2:0]        reg_word,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              m_req,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [31:0]       m_wdata,
    input  logic [31:0]       m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    input  logic              src_dreq,
    output logic              src_dack,
    input  logic              dst_dreq,
    output logic              dst_dack,
    output logic              irq_done,
    output logic              irq_abort
);

    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  count;
    ctrl_t             ctrl;
    logic              abort_flag, done_flag;
    logic              step, finish, abort_evt;
    logic [BUS_W-1:0]  elem_in, elem_q;
    logic              chan_en, dst_is_per;

    assign chan_en    = ctrl.en;
    assign dst_is_per = ctrl.dst_per;

    dma_xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wen    (reg_wen),
        .reg_word   (reg_word),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .step       (step),
        .finish     (finish),
        .abort_evt  (abort_evt),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .count      (count),
        .ctrl       (ctrl),
        .abort_flag (abort_flag),
        .done_flag  (done_flag)
    );

    dma_xfer_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .src_per   (ctrl.src_per),
        .dst_per   (ctrl.dst_per),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .count     (count),
        .src_dreq  (src_dreq),
        .dst_dreq  (dst_dreq),
        .m_ready   (m_ready),
        .m_err     (m_err),
        .elem_in   (elem_in),
        .m_req     (m_req),
        .m_write   (m_write),
        .m_addr    (m_addr),
        .elem_q    (elem_q),
        .step      (step),
        .finish    (finish),
        .abort_evt (abort_evt),
        .src_dack  (src_dack),
        .dst_dack  (dst_dack)
    );

    dma_xfer_lane u_lane (
        .rd_word (m_rdata),
        .src_lo  (src_addr[1:0]),
        .dst_lo  (dst_addr[1:0]),
        .wid     (ctrl.wid),
        .swap    (ctrl.swap),
        .elem_q  (elem_q),
        .elem_in (elem_in),
        .wr_word (m_wdata)
    );

    assign m_size    = ctrl.wid;
    assign irq_done  = done_flag;
    assign irq_abort = abort_flag & ctrl.abort_mask;

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              m_req,
    input logic              m_ready,
    input logic              m_err,
    input logic              m_write,
    input logic [ADDR_W-1:0] m_addr,
    input logic [31:0]       m_wdata,
    input logic              src_dack,
    input logic              dst_dack,
    input logic              dst_dreq,
    input logic              irq_abort,
    input logic              chan_en,
    input logic              dst_is_per,
    input logic              abort_flag,
    input logic              done_flag
);

    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ready && !(m_write && dst_is_per)) |=>
        (m_req && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

    // R7
    dst_pace_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_write && dst_is_per) |-> dst_dreq);

    // R7
    dack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({src_dack, dst_dack}));

    // R8
    done_stops_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> !chan_en);

    // R9
    err_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_ready && m_err) |=> (abort_flag && !chan_en));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_ready && m_err) |=> !m_req);

    // R10
    irq_abort_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_abort |-> abort_flag);

endmodule

bind dma_xfer_chan dma_xfer_chk #(.ADDR_W(ADDR_W)) u_dma_xfer_chk (.*);

// File: tb/test_dma_xfer_chan.sv
module test_dma_xfer_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        m_req, m_write;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [31:0] m_rdata = '0;
    logic        m_ready = 1'b0;
    logic        m_err = 1'b0;
    logic        src_dreq = 1'b1, dst_dreq = 1'b1;
    logic        src_dack, dst_dack, irq_done, irq_abort;

    always #10 clk = ~clk;

    dma_xfer_chan i_dma_xfer_chan (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req),
        .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .src_dreq(src_dreq), .src_dack(src_dack), .dst_dreq(dst_dreq),
        .dst_dack(dst_dack), .irq_done(irq_done), .irq_abort(irq_abort)
    );

    int checks = 0, fails = 0, cyc = 0;
    int bus_wait = 0, wcnt = 0, per_k = 0;
    int rd_cnt = 0, wr_cnt = 0, sdack_cnt = 0, ddack_cnt = 0, req_cnt = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] mem [64];

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] mask;
        logic [1:0]  size;
    } exp_t;
    exp_t sbq[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_init(input int i);
        return (32'(i) * 32'h0104_0913) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] per_val(input int k);
        return 32'hA500_1100 + 32'(k) * 32'h0102_0304;
    endfunction

    function automatic logic [31:0] tb_mask(input logic [1:0] w);
        return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int tb_bytes(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] tb_rev(input logic [31:0] v, input logic [1:0] w);
        logic [31:0] r;
        int n;
        n = tb_bytes(w);
        r = '0;
        for (int b = 0; b < n; b++) r[8*b +: 8] = v[8*(n-1-b) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ctl(input logic [1:0] w, input logic sw,
                                        input logic sp, input logic dp, input logic am);
        return {25'b0, am, dp, sp, sw, w, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_word = idx; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_word = idx;
        #2 v = reg_rdata;
    endtask

    // driver: push the writes a run must produce
    task automatic plan_run(input logic [31:0] src, input logic [31:0] dst,
                            input int n, input logic [1:0] w, input logic sw,
                            input logic sp, input logic dp);
        logic [31:0] sa, da, word, elem, m;
        int b;
        b = tb_bytes(w);
        m = tb_mask(w);
        for (int k = 0; k < n; k++) begin
            sa = sp ? src : src + 32'(k * b);
            da = dp ? dst : dst + 32'(k * b);
            word = sp ? per_val(k) : mem_init(int'(sa[7:2]));
            elem = (word >> (8 * sa[1:0])) & m;
            if (sw) elem = tb_rev(elem, w);
            sbq.push_back('{addr: da, data: elem << (8 * da[1:0]),
                            mask: m << (8 * da[1:0]), size: w});
        end
    endtask

    task automatic fresh;
        rd_cnt = 0; wr_cnt = 0; sdack_cnt = 0; ddack_cnt = 0; req_cnt = 0; per_k = 0;
    endtask

    task automatic start(input logic [31:0] src, input logic [31:0] dst,
                         input int n, input logic [31:0] c);
        reg_wr(3'd0, src);
        reg_wr(3'd1, dst);
        reg_wr(3'd2, 32'(n));
        reg_wr(3'd3, c);
    endtask

    task automatic wait_stop;
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(3'd3, v);
            if (!v[0]) break;
        end
    endtask

    task automatic drained(input string req);
        chk(sbq.size() == 0, req, 32'(sbq.size()), 32'd0);
        sbq.delete();
    endtask

    // bus slave: memory below 0x100, source peripheral at 0x1000
    always @(negedge clk) begin
        if (rst) begin
            m_ready = 1'b0; m_err = 1'b0; wcnt = 0;
        end else if (m_req && !m_ready && wcnt >= bus_wait) begin
            m_ready = 1'b1;
            wcnt = 0;
            m_err = err_en && (m_addr == err_addr);
            if (!m_write) begin
                if (m_addr[31:2] == 30'h400) begin
                    m_rdata = per_val(per_k);
                    per_k++;
                end else begin
                    m_rdata = mem[m_addr[7:2]];
                end
            end else if (!m_err && m_addr < 32'h100) begin
                for (int b = 0; b < 4; b++) begin
                    if (((tb_mask(m_size) << (8 * m_addr[1:0])) >> (8 * b)) & 32'h1)
                        mem[m_addr[7:2]][8*b +: 8] = m_wdata[8*b +: 8];
                end
            end
        end else begin
            m_ready = 1'b0;
            m_err = 1'b0;
            if (m_req) wcnt++;
        end
    end

    // monitor: pops expected writes and compares mid-cycle
    always @(negedge clk) begin
        exp_t e;
        #5;
        if (!rst) begin
            if (m_req) req_cnt++;
            if (src_dack) sdack_cnt++;
            if (dst_dack) ddack_cnt++;
            if (m_req && m_ready && !m_err) begin
                if (!m_write) begin
                    rd_cnt++;
                end else begin
                    chk(rd_cnt == wr_cnt + 1, "R3 read before write", 32'(rd_cnt), 32'(wr_cnt + 1));
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R8 unexpected write", m_addr, 32'hFFFF_FFFF);
                    end else begin
                        e = sbq.pop_front();
                        chk(m_addr == e.addr, "R4 write address", m_addr, e.addr);
                        chk((m_wdata & e.mask) == (e.data & e.mask), "R5 R6 write data",
                            m_wdata & e.mask, e.data & e.mask);
                        chk(m_size == e.size, "R5 size", 32'(m_size), 32'(e.size));
                    end
                    wr_cnt++;
                end
            end
        end
    end

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = mem_init(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            reg_rd(3'(i), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk({m_req, irq_done, irq_abort, src_dack, dst_dack} == 0, "R1 outputs idle",
            32'({m_req, irq_done, irq_abort, src_dack, dst_dack}), 0);

        // R2 readback
        reg_wr(3'd0, 32'h1234_5678);
        reg_rd(3'd0, v);
        chk(v == 32'h1234_5678, "R2 source readback", v, 32'h1234_5678);
        reg_wr(3'd3, 32'h0000_007E);
        reg_rd(3'd3, v);
        chk(v == 32'h7E, "R2 control readback", v, 32'h7E);
        reg_wr(3'd3, 0);

        // memory to memory, 32-bit, no swap
        fresh(); bus_wait = 2;
        plan_run(32'h00, 32'h80, 3, 2'd2, 0, 0, 0);
        start(32'h00, 32'h80, 3, ctl(2'd2, 0, 0, 0, 0));
        wait_stop();
        drained("R3 word copy");
        reg_rd(3'd2, v); chk(v == 0, "R8 count at end", v, 0);
        reg_rd(3'd4, v); chk(v == 32'h2, "R8 done status", v, 32'h2);
        chk(irq_done == 1'b1, "R8 irq_done", 32'(irq_done), 1);
        reg_rd(3'd0, v); chk(v == 32'h0C, "R4 source advanced", v, 32'h0C);
        reg_rd(3'd1, v); chk(v == 32'h8C, "R4 dest advanced", v, 32'h8C);
        chk(sdack_cnt + ddack_cnt == 0, "R7 no ack for memory", 32'(sdack_cnt + ddack_cnt), 0);
        reg_wr(3'd4, 32'h2);
        reg_rd(3'd4, v); chk(v == 0, "R10 done cleared", v, 0);
        chk(irq_done == 1'b0, "R10 irq_done cleared", 32'(irq_done), 0);

        // 16-bit with swap, no wait states
        fresh(); bus_wait = 0;
        plan_run(32'h22, 32'hA2, 5, 2'd1, 1, 0, 0);
        start(32'h22, 32'hA2, 5, ctl(2'd1, 1, 0, 0, 0));
        wait_stop();
        drained("R6 halfword swap");
        reg_rd(3'd0, v); chk(v == 32'h2C, "R4 halfword stride", v, 32'h2C);
        reg_wr(3'd4, 32'h3);

        // 8-bit, swap set but has no effect, odd addresses
        fresh(); bus_wait = 1;
        plan_run(32'h11, 32'hC3, 6, 2'd0, 0, 0, 0);
        start(32'h11, 32'hC3, 6, ctl(2'd0, 1, 0, 0, 0));
        wait_stop();
        drained("R6 byte swap no effect");
        reg_rd(3'd1, v); chk(v == 32'hC9, "R4 byte stride", v, 32'hC9);
        reg_wr(3'd4, 32'h3);

        // peripheral to memory with pacing
        fresh(); src_dreq = 1'b0;
        plan_run(32'h1000, 32'hE0, 4, 2'd2, 0, 1, 0);
        start(32'h1000, 32'hE0, 4, ctl(2'd2, 0, 1, 0, 0));
        repeat (20) @(negedge clk);
        chk(req_cnt == 0, "R7 source held off", 32'(req_cnt), 0);
        src_dreq = 1'b1;
        wait_stop();
        drained("R7 peripheral source");
        chk(sdack_cnt == 4, "R7 src_dack pulses", 32'(sdack_cnt), 4);
        chk(ddack_cnt == 0, "R7 no dst_dack", 32'(ddack_cnt), 0);
        reg_rd(3'd0, v); chk(v == 32'h1000, "R4 peripheral address fixed", v, 32'h1000);
        reg_wr(3'd4, 32'h3);

        // memory to peripheral, 32-bit swap, destination paced
        fresh(); dst_dreq = 1'b0; bus_wait = 1;
        plan_run(32'h40, 32'h2000, 3, 2'd2, 1, 0, 1);
        start(32'h40, 32'h2000, 3, ctl(2'd2, 1, 0, 1, 0));
        repeat (20) @(negedge clk);
        chk(rd_cnt == 1 && wr_cnt == 0, "R7 destination held off", 32'(wr_cnt), 0);
        dst_dreq = 1'b1;
        wait_stop();
        drained("R6 word swap to peripheral");
        chk(ddack_cnt == 3, "R7 dst_dack pulses", 32'(ddack_cnt), 3);
        reg_rd(3'd1, v); chk(v == 32'h2000, "R4 dest peripheral fixed", v, 32'h2000);
        reg_wr(3'd4, 32'h3);

        // peripheral to peripheral, 16-bit swap, upper lanes
        fresh(); bus_wait = 0;
        plan_run(32'h1000, 32'h2002, 3, 2'd1, 1, 1, 1);
        start(32'h1000, 32'h2002, 3, ctl(2'd1, 1, 1, 1, 0));
        wait_stop();
        drained("R5 upper lane placement");
        chk(sdack_cnt == 3 && ddack_cnt == 3, "R7 both acks",
            32'(sdack_cnt + ddack_cnt), 6);
        reg_wr(3'd4, 32'h3);

        // read error, mask set
        fresh(); err_en = 1'b1; err_addr = 32'h08;
        plan_run(32'h00, 32'h80, 2, 2'd2, 0, 0, 0);
        start(32'h00, 32'h80, 4, ctl(2'd2, 0, 0, 0, 1));
        wait_stop();
        repeat (5) @(negedge clk);
        drained("R9 read error stop");
        reg_rd(3'd4, v); chk(v == 32'h1, "R9 abort status", v, 32'h1);
        reg_rd(3'd2, v); chk(v == 2, "R9 count after read error", v, 2);
        chk(irq_abort == 1'b1, "R10 irq_abort masked on", 32'(irq_abort), 1);
        reg_wr(3'd4, 32'h1);
        reg_rd(3'd4, v); chk(v == 0, "R10 abort cleared", v, 0);
        chk(irq_abort == 1'b0, "R10 irq_abort cleared", 32'(irq_abort), 0);

        // write error, mask clear
        fresh(); err_addr = 32'h84;
        plan_run(32'h00, 32'h80, 1, 2'd2, 0, 0, 0);
        start(32'h00, 32'h80, 4, ctl(2'd2, 0, 0, 0, 0));
        wait_stop();
        repeat (5) @(negedge clk);
        drained("R9 write error stop");
        reg_rd(3'd2, v); chk(v == 3, "R9 failed element not counted", v, 3);
        reg_rd(3'd4, v); chk(v == 32'h1, "R9 abort on write", v, 32'h1);
        chk(irq_abort == 1'b0, "R10 irq_abort masked off", 32'(irq_abort), 0);
        reg_wr(3'd4, 32'h3);
        err_en = 1'b0;

        // zero count
        fresh();
        start(32'h00, 32'h80, 0, ctl(2'd2, 0, 0, 0, 0));
        wait_stop();
        reg_rd(3'd4, v); chk(v == 32'h2, "R8 zero count done", v, 32'h2);
        chk(req_cnt == 0, "R8 zero count no traffic", 32'(req_cnt), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule